// File: doc/BRIEF.md
# Serial Port Baud Clock Generator

This block turns the oscillator tick and two timer overflow streams into the bit-rate enables of a classic four-mode serial port. The serial mode field picks between a synchronous shift mode with a fixed divide-by-12, a 9-bit asynchronous mode with a fixed divide-by-64 or divide-by-32, and two asynchronous modes whose rate follows a timer. In the timer-driven modes, transmit and receive each choose their own overflow source, either timer 1 or timer 2. Each then divides the chosen overflow stream by 32, or by 16 when the rate-doubling bit is set.

All outputs are one-cycle enable pulses in the system clock domain, registered, and high in the cycle after the input tick that completes a count. The shift register, framing and the timers sit outside the block. Every prescaler clears when the mode field changes. Any tick that arrives in the cycle of the change is dropped.

Top module: `baud_clk_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, tx_bit_en, rx_bit_en and shift_en are all 0.
- R2: With mode_sel = 2'b00 (synchronous shift mode), shift_en pulses once for every 12 osc_tick cycles, and tx_bit_en and rx_bit_en stay 0. In every other mode, shift_en stays 0.
- R3: With mode_sel = 2'b10 (fixed-rate 9-bit mode), tx_bit_en and rx_bit_en pulse together once for every 64 osc_tick cycles when dbl_rate = 0, and once for every 32 when dbl_rate = 1.
- R4: With mode_sel = 2'b01 or 2'b11 (timer-rate modes) and dbl_rate = 0, each of tx_bit_en and rx_bit_en pulses once for every 32 pulses of its selected overflow source.
- R5: In the timer-rate modes with dbl_rate = 1, each path pulses once for every 16 pulses of its selected source.
- R6: tx_use_t2 = 1 selects t2_ovf for the transmit path and 0 selects t1_ovf. rx_use_t2 does the same for the receive path, independently of tx_use_t2. Pulses on a path's unselected source do not advance that path.
- R7: In any cycle where mode_sel differs from its value in the previous cycle (the reset value is 2'b00), all prescalers return to zero and that cycle's ticks are not counted, so no enable rises in the next cycle.
- R8: Each enable is high for exactly one cycle, namely the cycle after the clock edge that samples the completing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator tick enable |
| mode_sel | input | 2 | Serial mode: bit 1 is the high mode bit, bit 0 the low |
| dbl_rate | input | 1 | Rate doubling: removes the final divide-by-2 |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| t2_ovf | input | 1 | Timer 2 overflow pulse |
| tx_use_t2 | input | 1 | Transmit source: 1 = timer 2, 0 = timer 1 |
| rx_use_t2 | input | 1 | Receive source: 1 = timer 2, 0 = timer 1 |
| tx_bit_en | output | 1 | Transmit bit-rate enable pulse |
| rx_bit_en | output | 1 | Receive bit-rate enable pulse |
| shift_en | output | 1 | Synchronous shift enable pulse |

## Verification
The hardest case to reach is a mode change that lands on the very tick that would complete a count. In that case the enable must stay low and the count must restart from zero. A directed sequence loads eleven shift ticks, then switches to the fixed-rate mode with a tick present in the switch cycle. Random segments also flip the mode at random points, with both overflow streams active. Another directed case splits transmit and receive onto different timers and feeds only one of them, which shows that the idle path holds its count.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_UART8 = 2'b01,
    MODE_FIX9  = 2'b10,
    MODE_VAR9  = 2'b11
  } ser_mode_e;

  localparam int SHIFT_DIV = 12;
  localparam int FIX_PRE   = 32;
  localparam int VAR_PRE   = 16;
  localparam int NPATH     = 2;  // 0 = transmit, 1 = receive
endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic wrap
);
  localparam int W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt;

  assign wrap = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rate_path.sv
module rate_path #(
  parameter int PRE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic bypass,
  output logic pulse
);
  logic pre_wrap;
  logic half_wrap;

  div_stage #(.N(PRE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .wrap(pre_wrap)
  );

  div_stage #(.N(2)) u_half (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(pre_wrap && !bypass), .wrap(half_wrap)
  );

  assign pulse = bypass ? pre_wrap : half_wrap;
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import baud_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [1:0] mode_sel,
  input  logic       dbl_rate,
  input  logic       t1_ovf,
  input  logic       t2_ovf,
  input  logic       tx_use_t2,
  input  logic       rx_use_t2,
  output logic       tx_bit_en,
  output logic       rx_bit_en,
  output logic       shift_en
);
  ser_mode_e mode_now, mode_q;
  logic mode_chg, live;
  logic is_shift, is_fix, is_var;
  logic sh_pulse, fix_pulse;
  logic [NPATH-1:0] use_t2, var_pulse;

  assign mode_now = ser_mode_e'(mode_sel);
  assign mode_chg = (mode_now != mode_q);
  assign live     = !mode_chg;
  assign is_shift = (mode_now == MODE_SHIFT);
  assign is_fix   = (mode_now == MODE_FIX9);
  assign is_var   = (mode_now == MODE_UART8) || (mode_now == MODE_VAR9);
  assign use_t2   = {rx_use_t2, tx_use_t2};

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_SHIFT;
    else        mode_q <= mode_now;
  end

  div_stage #(.N(SHIFT_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg),
    .tick(live && is_shift && osc_tick), .wrap(sh_pulse)
  );

  rate_path #(.PRE(FIX_PRE)) u_fixed (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg),
    .tick(live && is_fix && osc_tick), .bypass(dbl_rate), .pulse(fix_pulse)
  );

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic src;
    assign src = use_t2[g] ? t2_ovf : t1_ovf;
    rate_path #(.PRE(VAR_PRE)) u_var (
      .clk(clk), .rst_n(rst_n), .clr(mode_chg),
      .tick(live && is_var && src), .bypass(dbl_rate), .pulse(var_pulse[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_bit_en <= 1'b0;
      rx_bit_en <= 1'b0;
      shift_en  <= 1'b0;
    end else begin
      tx_bit_en <= var_pulse[0] || fix_pulse;
      rx_bit_en <= var_pulse[1] || fix_pulse;
      shift_en  <= sh_pulse;
    end
  end

  AST_SHIFT_ONLY_M0: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (mode_q == MODE_SHIFT)); // R2
  AST_NO_BITS_IN_M0: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_en || rx_bit_en) |-> (mode_q != MODE_SHIFT)); // R2
  AST_FIXED_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FIX9) |-> (tx_bit_en == rx_bit_en)); // R3
  AST_CHANGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!tx_bit_en && !rx_bit_en && !shift_en)); // R7
  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_en |=> !tx_bit_en); // R8
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_en |=> !rx_bit_en); // R8
  AST_SHIFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en); // R8
endmodule

// File: tb/tb_baud_clk_gen.sv
module tb_baud_clk_gen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, osc_tick, dbl_rate, t1_ovf, t2_ovf, tx_use_t2, rx_use_t2;
  logic [1:0] mode_sel;
  logic tx_bit_en, rx_bit_en, shift_en;

  baud_clk_gen dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .mode_sel(mode_sel),
    .dbl_rate(dbl_rate), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf),
    .tx_use_t2(tx_use_t2), .rx_use_t2(rx_use_t2),
    .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en), .shift_en(shift_en)
  );

  int checks = 0;
  int errors = 0;
  int k_sh, k_fx, k_tx, k_rx;
  logic [1:0] pm;
  logic e_tx, e_rx, e_sh;
  string tag_tx, tag_rx, tag_sh;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    k_sh = 0; k_fx = 0; k_tx = 0; k_rx = 0; pm = 2'b00;
  endfunction

  // Expected enables for the next cycle, from R2..R7
  function automatic void model(input logic [1:0] m, input logic s, input logic o,
                                input logic a, input logic b, input logic ts, input logic rs);
    int d;
    e_tx = 0; e_rx = 0; e_sh = 0;
    tag_sh = "R2"; tag_tx = "R2"; tag_rx = "R2";
    if (m != pm) begin
      k_sh = 0; k_fx = 0; k_tx = 0; k_rx = 0;
      tag_sh = "R7"; tag_tx = "R7"; tag_rx = "R7";
    end else if (m == 2'b00) begin
      if (o) k_sh++;
      if (k_sh == 12) begin k_sh = 0; e_sh = 1; end
    end else if (m == 2'b10) begin
      tag_tx = "R3"; tag_rx = "R3";
      d = s ? 32 : 64;
      if (o) k_fx++;
      if (k_fx == d) begin k_fx = 0; e_tx = 1; e_rx = 1; end
    end else begin
      d = s ? 16 : 32;
      tag_tx = (ts != rs) ? "R6" : (s ? "R5" : "R4");
      tag_rx = tag_tx;
      if (ts ? b : a) k_tx++;
      if (rs ? b : a) k_rx++;
      if (k_tx == d) begin k_tx = 0; e_tx = 1; end
      if (k_rx == d) begin k_rx = 0; e_rx = 1; end
    end
    pm = m;
  endfunction

  task automatic step(input logic [1:0] m, input logic s, input logic o,
                      input logic a, input logic b, input logic ts, input logic rs);
    mode_sel = m; dbl_rate = s; osc_tick = o; t1_ovf = a; t2_ovf = b;
    tx_use_t2 = ts; rx_use_t2 = rs;
    model(m, s, o, a, b, ts, rs);
    @(negedge clk);
    chk(tag_tx, "tx_bit_en", tx_bit_en, e_tx);
    chk(tag_rx, "rx_bit_en", rx_bit_en, e_rx);
    chk(tag_sh, "shift_en", shift_en, e_sh);
  endtask

  task automatic do_reset();
    rst_n = 0; mode_sel = 0; dbl_rate = 0; osc_tick = 1; t1_ovf = 1; t2_ovf = 1;
    tx_use_t2 = 0; rx_use_t2 = 0;
    @(negedge clk); @(negedge clk);
    chk("R1", "tx_bit_en in reset", tx_bit_en, 1'b0);
    chk("R1", "rx_bit_en in reset", rx_bit_en, 1'b0);
    chk("R1", "shift_en in reset", shift_en, 1'b0);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    rst_n = 0;
    do_reset();
    step(2'b00, 0, 0, 0, 0, 0, 0);
    chk("R1", "tx_bit_en after reset", tx_bit_en, 1'b0);
    chk("R1", "shift_en after reset", shift_en, 1'b0);

    // R8: exactly 32 timer 1 pulses, then one quiet cycle
    do_reset();
    step(2'b01, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 31; i++) step(2'b01, 0, 0, 1, 0, 0, 0);
    chk("R8", "tx_bit_en before 32nd", tx_bit_en, 1'b0);
    step(2'b01, 0, 0, 1, 0, 0, 0);
    chk("R8", "tx_bit_en after 32nd", tx_bit_en, 1'b1);
    step(2'b01, 0, 0, 0, 0, 0, 0);
    chk("R8", "tx_bit_en one cycle only", tx_bit_en, 1'b0);

    // R7: mode change on the completing tick is dropped
    do_reset();
    for (int i = 0; i < 11; i++) step(2'b00, 0, 1, 0, 0, 0, 0);
    step(2'b10, 0, 1, 0, 0, 0, 0);
    chk("R7", "shift_en after change", shift_en, 1'b0);
    chk("R7", "tx_bit_en after change", tx_bit_en, 1'b0);
    for (int i = 0; i < 63; i++) step(2'b10, 0, 1, 0, 0, 0, 0);
    chk("R3", "tx_bit_en before 64th", tx_bit_en, 1'b0);
    step(2'b10, 0, 1, 0, 0, 0, 0);
    chk("R3", "tx_bit_en after 64th", tx_bit_en, 1'b1);
    chk("R3", "rx_bit_en after 64th", rx_bit_en, 1'b1);

    // R6: split sources, feed only timer 1
    do_reset();
    step(2'b11, 1, 0, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) step(2'b11, 1, 0, 1, 0, 1, 0);
    chk("R6", "rx_bit_en on timer 1", rx_bit_en, 1'b1);
    chk("R6", "tx_bit_en ignores timer 1", tx_bit_en, 1'b0);

    // Random segments
    for (int seg = 0; seg < 24; seg++) begin
      logic [1:0] m;
      logic s, ts, rs;
      int dens;
      do_reset();
      m = 2'($urandom % 4);
      s = 1'($urandom % 2);
      ts = 1'($urandom % 2);
      rs = 1'($urandom % 2);
      dens = 1 + int'($urandom % 4);
      for (int c = 0; c < 1200; c++) begin
        if ($urandom % 300 == 0) m = 2'($urandom % 4);
        step(m, s, ($urandom % 5) < dens, 1'($urandom % 2), 1'($urandom % 2), ts, rs);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule